// File: doc/BRIEF.md
# Speculative Privilege Mode Tracker

This block follows the user/supervisor privilege level through an out-of-order core without serializing on every mode switch. A forward-looking fetch copy supplies the level that address translation and the fetch tag use. One saved copy per branch checkpoint lets a mispredict repair that copy. A committed copy held at retire is the recovery point for exceptions and full flushes. A trap entry or return switches the fetch copy as soon as it is fetched, so every younger fetch is tagged with the new level. The instruction doing the switch keeps the level it was fetched under.

Decode compares each privileged opcode against the tag that came with it. A user-mode tag raises an illegal flag. That flag travels down the pipe and comes back at retire, where the block turns it into a precise exception request. The committed copy changes only when a non-faulting mode-switching instruction retires. The level is encoded as 1 for supervisor and 0 for user throughout.

Top module: `spec_priv_tracker`

## Requirements
- R1: After reset, fe_mode and cm_mode read supervisor (1) and every checkpoint slot is empty.
- R2: When fe_valid and fe_chg are high with neither flush nor ck_restore, fe_mode keeps its old value in that cycle (the tag of the switching op) and equals fe_new_mode from the next cycle.
- R3: ck_alloc stores the fe_mode shown in that cycle into slot ck_alloc_id. A ck_restore of a filled slot shows the stored level on fe_mode in the same cycle and keeps it afterwards.
- R4: flush shows cm_mode on fe_mode in the same cycle, keeps it afterwards, and empties every checkpoint slot.
- R5: flush wins over ck_restore, which wins over a fetched mode switch. With none of them, fe_mode holds.
- R6: cm_mode takes rt_new_mode after a cycle with rt_valid, rt_chg and not rt_viol, and is unchanged otherwise.
- R7: dec_illegal is high in the same cycle exactly when dec_valid and dec_priv are high and dec_tag is user (0).
- R8: rt_exc is high exactly when rt_valid and rt_viol are high. A faulting op never changes cm_mode.
- R9: ck_free empties a slot, and a ck_restore of an empty slot shows cm_mode. An allocate beats a free of the same slot in the same cycle, and flush beats an allocate.
- R10: Allocating, freeing or restoring one slot leaves the stored level of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fe_valid | input | 1 | A micro-op is fetched this cycle |
| fe_chg | input | 1 | The fetched op switches privilege level |
| fe_new_mode | input | 1 | Level the switching op enters |
| fe_mode | output | 1 | Level used by translation and as the fetch tag |
| dec_valid | input | 1 | A micro-op is in decode |
| dec_priv | input | 1 | The decoded op is privileged |
| dec_tag | input | 1 | Fetch-level tag of the decoded op |
| dec_illegal | output | 1 | Privilege violation flag for the decoded op |
| ck_alloc | input | 1 | Create a checkpoint |
| ck_alloc_id | input | CKPT_IDW | Slot of the new checkpoint |
| ck_free | input | 1 | Release a checkpoint |
| ck_free_id | input | CKPT_IDW | Slot to release |
| ck_restore | input | 1 | Mispredict redirect |
| ck_restore_id | input | CKPT_IDW | Slot of the mispredicted branch |
| flush | input | 1 | Exception or full pipeline flush |
| rt_valid | input | 1 | A micro-op retires |
| rt_chg | input | 1 | The retiring op switches level |
| rt_new_mode | input | 1 | Level the retiring op enters |
| rt_viol | input | 1 | Violation flag carried by the retiring op |
| rt_exc | output | 1 | Precise privilege exception request |
| cm_mode | output | 1 | Committed level |

## Verification
Directed cases come first. Each isolates one source of the fetch level: a fetched switch, a restore of a filled slot, a restore of a freed slot, and a flush. Together they show which copy drives fe_mode in each case. Random traffic then mixes overlapping allocates, frees, restores, flushes and retirements, so the priority order between the three sources and slot independence are exercised under collisions. Decode and retire patterns cover every combination of the privileged, tag, switch and violation bits. These patterns separate a correct illegal flag from one that ignores the tag, and a gated commit from one that lets faulting ops through.

// File: rtl/spt_pkg.sv
package spt_pkg;
   typedef enum logic {
      PM_USER  = 1'b0,
      PM_SUPER = 1'b1
   } pmode_e;
endpackage

// File: rtl/spt_ckpt_file.sv
// Per-checkpoint saved level with a filled bit per slot.
module spt_ckpt_file #(
   parameter int   IDW        = 3,
   parameter logic RESET_MODE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           alloc,
   input  logic [IDW-1:0] alloc_id,
   input  logic           alloc_mode,
   input  logic           free,
   input  logic [IDW-1:0] free_id,
   input  logic [IDW-1:0] rd_id,
   output logic           rd_mode,
   output logic           rd_hit
);
   localparam int NSLOT = 1 << IDW;

   logic [NSLOT-1:0] slot_full;
   logic [NSLOT-1:0] slot_mode;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic full_r;
      logic mode_r;
      logic wr_hit;
      logic fr_hit;
      assign wr_hit = alloc && (alloc_id == IDW'(i));
      assign fr_hit = free && (free_id == IDW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_r <= 1'b0;
            mode_r <= RESET_MODE;
         end else if (clear) begin
            full_r <= 1'b0;
         end else if (wr_hit) begin
            full_r <= 1'b1;
            mode_r <= alloc_mode;
         end else if (fr_hit) begin
            full_r <= 1'b0;
         end
      end
      assign slot_full[i] = full_r;
      assign slot_mode[i] = mode_r;
   end

   assign rd_mode = slot_mode[rd_id];
   assign rd_hit  = slot_full[rd_id];
endmodule

// File: rtl/spt_future.sv
// Fetch-side forward copy with same-cycle repair bypass.
module spt_future #(
   parameter logic RESET_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic cm_mode,
   input  logic restore,
   input  logic ck_mode,
   input  logic ck_hit,
   input  logic fetch_chg,
   input  logic fetch_mode,
   output logic eff_mode,
   output logic fut_q
);
   logic fut_d;

   always_comb begin
      if (flush)        eff_mode = cm_mode;
      else if (restore) eff_mode = ck_hit ? ck_mode : cm_mode;
      else              eff_mode = fut_q;
   end

   always_comb begin
      if (flush || restore) fut_d = eff_mode;
      else if (fetch_chg)   fut_d = fetch_mode;
      else                  fut_d = fut_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fut_q <= RESET_MODE;
      else        fut_q <= fut_d;
   end
endmodule

// File: rtl/spt_commit.sv
// Retire-side committed copy and precise exception request.
module spt_commit #(
   parameter logic RESET_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rt_valid,
   input  logic rt_chg,
   input  logic rt_new_mode,
   input  logic rt_viol,
   output logic cm_q,
   output logic exc
);
   logic take;
   assign take = rt_valid && rt_chg && !rt_viol;
   assign exc  = rt_valid && rt_viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cm_q <= RESET_MODE;
      else if (take) cm_q <= rt_new_mode;
   end
endmodule

// File: rtl/spt_dec_chk.sv
// Decode check of privileged ops against the fetch tag.
module spt_dec_chk
   import spt_pkg::*;
#(
   parameter bit DEC_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic priv,
   input  logic tag,
   output logic illegal
);
   logic hit;
   assign hit = valid && priv && (pmode_e'(tag) == PM_USER);

   if (DEC_REG) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit;
      end
      assign illegal = hit_q;
   end else begin : g_comb
      assign illegal = hit;
   end
endmodule

// File: rtl/spec_priv_tracker.sv
module spec_priv_tracker #(
   parameter int   CKPT_IDW   = 3,
   parameter logic RESET_MODE = 1'b1,
   parameter bit   DEC_REG    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fe_valid,
   input  logic                fe_chg,
   input  logic                fe_new_mode,
   output logic                fe_mode,
   input  logic                dec_valid,
   input  logic                dec_priv,
   input  logic                dec_tag,
   output logic                dec_illegal,
   input  logic                ck_alloc,
   input  logic [CKPT_IDW-1:0] ck_alloc_id,
   input  logic                ck_free,
   input  logic [CKPT_IDW-1:0] ck_free_id,
   input  logic                ck_restore,
   input  logic [CKPT_IDW-1:0] ck_restore_id,
   input  logic                flush,
   input  logic                rt_valid,
   input  logic                rt_chg,
   input  logic                rt_new_mode,
   input  logic                rt_viol,
   output logic                rt_exc,
   output logic                cm_mode
);
   localparam int NSLOT = 1 << CKPT_IDW;

   if (NSLOT < 8) begin : g_bad_depth
      $error("spec_priv_tracker: at least 8 checkpoints required");
   end

   logic ck_mode;
   logic ck_hit;
   logic fut_q;
   logic eff_mode;

   spt_commit #(.RESET_MODE(RESET_MODE)) u_commit (
      .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_chg(rt_chg),
      .rt_new_mode(rt_new_mode), .rt_viol(rt_viol), .cm_q(cm_mode), .exc(rt_exc)
   );

   spt_ckpt_file #(.IDW(CKPT_IDW), .RESET_MODE(RESET_MODE)) u_ckpt (
      .clk(clk), .rst_n(rst_n), .clear(flush), .alloc(ck_alloc),
      .alloc_id(ck_alloc_id), .alloc_mode(eff_mode), .free(ck_free),
      .free_id(ck_free_id), .rd_id(ck_restore_id), .rd_mode(ck_mode), .rd_hit(ck_hit)
   );

   spt_future #(.RESET_MODE(RESET_MODE)) u_future (
      .clk(clk), .rst_n(rst_n), .flush(flush), .cm_mode(cm_mode),
      .restore(ck_restore), .ck_mode(ck_mode), .ck_hit(ck_hit),
      .fetch_chg(fe_valid && fe_chg), .fetch_mode(fe_new_mode),
      .eff_mode(eff_mode), .fut_q(fut_q)
   );

   spt_dec_chk #(.DEC_REG(DEC_REG)) u_dec (
      .clk(clk), .rst_n(rst_n), .valid(dec_valid), .priv(dec_priv),
      .tag(dec_tag), .illegal(dec_illegal)
   );

   assign fe_mode = eff_mode;
endmodule

// File: rtl/spec_priv_tracker_chk.sv
module spec_priv_tracker_chk #(
   parameter bit DEC_REG = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic fe_valid,
   input logic fe_chg,
   input logic fe_new_mode,
   input logic fe_mode,
   input logic fut_q,
   input logic dec_valid,
   input logic dec_priv,
   input logic dec_tag,
   input logic dec_illegal,
   input logic ck_restore,
   input logic flush,
   input logic rt_valid,
   input logic rt_chg,
   input logic rt_viol,
   input logic rt_exc,
   input logic cm_mode
);
   // R2
   fetch_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_valid && fe_chg && !flush && !ck_restore |=> fut_q == $past(fe_new_mode));
   // R3
   restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_restore && !flush |=> fut_q == $past(fe_mode));
   // R4
   flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> fut_q == $past(cm_mode));
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && !ck_restore && !(fe_valid && fe_chg) |=> $stable(fut_q));
   // R6
   commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rt_valid && rt_chg && !rt_viol) |=> $stable(cm_mode));
   // R8
   exc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rt_exc |-> rt_valid);
   // R7
   super_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !DEC_REG && dec_valid && dec_priv && dec_tag |-> !dec_illegal);
endmodule

bind spec_priv_tracker spec_priv_tracker_chk #(.DEC_REG(DEC_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_chg(fe_chg),
   .fe_new_mode(fe_new_mode), .fe_mode(fe_mode), .fut_q(fut_q),
   .dec_valid(dec_valid), .dec_priv(dec_priv), .dec_tag(dec_tag),
   .dec_illegal(dec_illegal), .ck_restore(ck_restore), .flush(flush),
   .rt_valid(rt_valid), .rt_chg(rt_chg), .rt_viol(rt_viol),
   .rt_exc(rt_exc), .cm_mode(cm_mode)
);

// File: tb/sim_spec_priv_tracker.sv
`timescale 1ns/1ps
module sim_spec_priv_tracker;
   localparam int IDW = 3;
   localparam int NS  = 1 << IDW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic fe_valid, fe_chg, fe_new_mode, fe_mode;
   logic dec_valid, dec_priv, dec_tag, dec_illegal;
   logic ck_alloc, ck_free, ck_restore, flush;
   logic [IDW-1:0] ck_alloc_id, ck_free_id, ck_restore_id;
   logic rt_valid, rt_chg, rt_new_mode, rt_viol, rt_exc, cm_mode;

   spec_priv_tracker u0 (.*);

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   logic m_fut, m_cm;
   logic [NS-1:0] m_full, m_mode;

   task automatic chk(input string r, input logic act, input logic exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", r, act, exp, $time);
      end
   endtask

   task automatic idle();
      fe_valid = 0; fe_chg = 0; fe_new_mode = 0;
      dec_valid = 0; dec_priv = 0; dec_tag = 0;
      ck_alloc = 0; ck_free = 0; ck_restore = 0; flush = 0;
      ck_alloc_id = '0; ck_free_id = '0; ck_restore_id = '0;
      rt_valid = 0; rt_chg = 0; rt_new_mode = 0; rt_viol = 0;
   endtask

   function automatic logic exp_eff();
      if (flush) return m_cm;
      if (ck_restore) return m_full[ck_restore_id] ? m_mode[ck_restore_id] : m_cm;
      return m_fut;
   endfunction

   // Inputs are set after a falling edge; check, update model, move to next falling edge.
   task automatic step();
      logic e;
      #1;
      e = exp_eff();
      chk(flush ? "R4" : (ck_restore ? "R3" : "R2"), fe_mode, e);
      chk("R6", cm_mode, m_cm);
      chk("R7", dec_illegal, dec_valid && dec_priv && !dec_tag);
      chk("R8", rt_exc, rt_valid && rt_viol);
      if (flush || ck_restore) m_fut = e;
      else if (fe_valid && fe_chg) m_fut = fe_new_mode;
      if (flush) m_full = '0;
      else begin
         if (ck_free) m_full[ck_free_id] = 1'b0;
         if (ck_alloc) begin
            m_full[ck_alloc_id] = 1'b1;
            m_mode[ck_alloc_id] = e;
         end
      end
      if (rt_valid && rt_chg && !rt_viol) m_cm = rt_new_mode;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      idle();
      m_fut = 1; m_cm = 1; m_full = '0; m_mode = '1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1: reset state
      chk("R1", fe_mode, 1'b1);
      chk("R1", cm_mode, 1'b1);
      ck_restore = 1; ck_restore_id = 3'd5; #1;
      chk("R1", fe_mode, cm_mode);
      idle();
      @(negedge clk);

      // R2: fetch switch to user; tag stays supervisor this cycle
      fe_valid = 1; fe_chg = 1; fe_new_mode = 0; step(); idle();
      #1 chk("R2", fe_mode, 1'b0);
      // R7: privileged op tagged user is illegal
      dec_valid = 1; dec_priv = 1; dec_tag = 0; #1 chk("R7", dec_illegal, 1'b1);
      step(); idle();

      // R3 and R10: slot 2 holds user, slot 6 holds supervisor
      ck_alloc = 1; ck_alloc_id = 3'd2; step(); idle();
      fe_valid = 1; fe_chg = 1; fe_new_mode = 1; step(); idle();
      ck_alloc = 1; ck_alloc_id = 3'd6; step(); idle();
      ck_restore = 1; ck_restore_id = 3'd2; #1 chk("R3", fe_mode, 1'b0);
      step(); idle();
      #1 chk("R3", fe_mode, 1'b0);
      ck_restore = 1; ck_restore_id = 3'd6; #1 chk("R10", fe_mode, 1'b1);
      step(); idle();

      // R9: free then restore falls back to committed
      fe_valid = 1; fe_chg = 1; fe_new_mode = 0; step(); idle();
      ck_free = 1; ck_free_id = 3'd6; step(); idle();
      ck_restore = 1; ck_restore_id = 3'd6; #1 chk("R9", fe_mode, cm_mode);
      step(); idle();
      // R9: allocate beats free of same slot
      ck_alloc = 1; ck_alloc_id = 3'd4; ck_free = 1; ck_free_id = 3'd4; step(); idle();
      fe_valid = 1; fe_chg = 1; fe_new_mode = 0; step(); idle();
      ck_restore = 1; ck_restore_id = 3'd4; #1 chk("R9", fe_mode, m_mode[4]);
      step(); idle();

      // R6/R8: faulting retire does not commit; clean one does
      rt_valid = 1; rt_chg = 1; rt_new_mode = 0; rt_viol = 1;
      #1 chk("R8", rt_exc, 1'b1); step(); idle();
      #1 chk("R6", cm_mode, 1'b1);
      rt_valid = 1; rt_chg = 1; rt_new_mode = 0; step(); idle();
      #1 chk("R6", cm_mode, 1'b0);

      // R4/R5: flush beats restore and switch, clears slots
      ck_alloc = 1; ck_alloc_id = 3'd1; step(); idle();
      flush = 1; ck_restore = 1; ck_restore_id = 3'd1; fe_valid = 1; fe_chg = 1; fe_new_mode = 1;
      #1 chk("R5", fe_mode, cm_mode); step(); idle();
      ck_restore = 1; ck_restore_id = 3'd1; #1 chk("R4", fe_mode, cm_mode); step(); idle();

      // Random traffic
      for (int n = 0; n < 3000; n++) begin
         fe_valid      = $urandom_range(0, 1);
         fe_chg        = ($urandom_range(0, 3) == 0);
         fe_new_mode   = $urandom_range(0, 1);
         dec_valid     = $urandom_range(0, 1);
         dec_priv      = $urandom_range(0, 1);
         dec_tag       = $urandom_range(0, 1);
         ck_alloc      = ($urandom_range(0, 3) == 0);
         ck_alloc_id   = IDW'($urandom_range(0, NS - 1));
         ck_free       = ($urandom_range(0, 5) == 0);
         ck_free_id    = IDW'($urandom_range(0, NS - 1));
         ck_restore    = ($urandom_range(0, 7) == 0);
         ck_restore_id = IDW'($urandom_range(0, NS - 1));
         flush         = ($urandom_range(0, 19) == 0);
         rt_valid      = $urandom_range(0, 1);
         rt_chg        = ($urandom_range(0, 2) == 0);
         rt_new_mode   = $urandom_range(0, 1);
         rt_viol       = ($urandom_range(0, 4) == 0);
         step();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule